// File: doc/BRIEF.md
# Barrel Shifter with Condition Flags

This block is the shift datapath of a 32-bit integer core. In one cycle it shifts an operand right arithmetically, right logically or left logically. The distance is either a 5-bit immediate, zero-extended, or the low five bits of a register value. The block has no storage, so the result and flags follow the inputs in the same cycle.

Next to the shifted word it produces a condition-flag update. The update has a value vector and a write-enable vector with one bit per flag. Zero and sign describe the result. Carry holds the last bit moved out of the word. Overflow is written as zero. The saturation flag is left alone.

The flag vectors use this bit layout: bit 0 zero, bit 1 sign, bit 2 carry, bit 3 overflow, bit 4 saturation.

Top module: `shf_unit`

## Requirements
- R1: With `use_imm_i`=1 the shift distance is `imm_i` zero-extended and `reg_amt_i` has no effect. With `use_imm_i`=0 the distance is `reg_amt_i[4:0]`; bits 31:5 of `reg_amt_i` and all of `imm_i` have no effect.
- R2: Operation code 0 (arithmetic right) copies operand bit 31 into every vacated upper position.
- R3: Operation code 1 (logical right) fills vacated upper positions with zeros.
- R4: Operation code 2 (logical left) fills vacated lower positions with zeros and drops bits moved past bit 31.
- R5: For a right shift by n>0, `flag_val_o[2]` equals operand bit n-1.
- R6: For a left shift by n>0, `flag_val_o[2]` equals operand bit 32-n.
- R7: A distance of 0 returns the operand unchanged and clears `flag_val_o[2]`, for every operation code.
- R8: `flag_val_o[0]` is 1 exactly when the result is all zeros, and `flag_val_o[1]` equals result bit 31.
- R9: `flag_val_o[3]` is always 0 and `flag_wr_o` is always 5'b01111: zero, sign, carry and overflow are written, saturation is not. `flag_val_o[4]` is 0.
- R10: Operation code 3 behaves exactly like code 1 (logical right).
- R11: The outputs depend only on the present inputs; a change at the inputs shows at the outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Word to be shifted |
| imm_i | input | 5 | Immediate shift distance |
| reg_amt_i | input | 32 | Register value; its low 5 bits give the distance |
| use_imm_i | input | 1 | 1 selects the immediate, 0 selects the register value |
| op_i | input | 2 | 0 arithmetic right, 1 logical right, 2 logical left, 3 logical right |
| result_o | output | 32 | Shifted word |
| flag_val_o | output | 5 | New flag values: {sat, ov, cy, s, z} |
| flag_wr_o | output | 5 | Per-flag write enables, same layout |

## Verification
A table of directed vectors uses operands with the sign bit set and clear, single-bit markers at the carry position, and distances of 0, 1, 4, 8 and 31. These vectors separate sign fill from zero fill, and show whether carry comes from bit n-1 or bit 32-n. Register distances with nonzero upper bits, including one whose low five bits are zero, check the masking of the distance. An exhaustive sweep over all 32 distances for every operation code, on a patterned operand, compares against a model built from the language's own shift operators. Directed cases then show that the unselected distance source has no effect, that operation code 3 matches logical right, and that outputs follow an input change within the same cycle.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SH_SAR  = 2'd0,
        SH_SHR  = 2'd1,
        SH_SHL  = 2'd2,
        SH_SHR2 = 2'd3
    } shift_op_e;

    typedef struct packed {
        logic sat;
        logic ov;
        logic cy;
        logic s;
        logic z;
    } flag_vec_t;

    localparam int FLAG_N = 5;

    localparam flag_vec_t FLAG_WR_SHIFT = '{sat: 1'b0, ov: 1'b1, cy: 1'b1, s: 1'b1, z: 1'b1};

    typedef struct packed {
        logic left;
        logic arith;
    } shift_ctl_t;

    function automatic shift_ctl_t decode_op(input logic [1:0] code);
        shift_ctl_t c;
        c.left  = (code == SH_SHL);
        c.arith = (code == SH_SAR);
        return c;
    endfunction

endpackage

// File: rtl/shf_amount_sel.sv
module shf_amount_sel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] reg_amt_i,
    input  logic              use_imm_i,
    output logic [AMT_W-1:0]  amt_o
);
    logic amt_hi_unused;
    assign amt_hi_unused = ^reg_amt_i[DATA_W-1:AMT_W];

    always_comb begin
        if (use_imm_i) amt_o = imm_i;
        else           amt_o = reg_amt_i[AMT_W-1:0];
    end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              fill_i,
    output logic [DATA_W-1:0] data_o,
    output logic              last_out_o
);
    localparam int VW = DATA_W + 1;

    logic [VW-1:0] stg [AMT_W+1];

    assign stg[0] = {data_i, 1'b0};

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        logic [VW-1:0] moved;
        assign moved      = {{SH{fill_i}}, stg[k][VW-1:SH]};
        assign stg[k + 1] = amt_i[k] ? moved : stg[k];
    end

    assign data_o     = stg[AMT_W][VW-1:1];
    assign last_out_o = stg[AMT_W][0];
endmodule

// File: rtl/shf_flag_gen.sv
module shf_flag_gen
    import shf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result_i,
    input  logic              carry_i,
    output flag_vec_t         val_o,
    output flag_vec_t         wr_o
);
    always_comb begin
        val_o     = '0;
        val_o.z   = (result_i == '0);
        val_o.s   = result_i[DATA_W-1];
        val_o.cy  = carry_i;
        val_o.ov  = 1'b0;
        val_o.sat = 1'b0;
        wr_o      = FLAG_WR_SHIFT;
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [AMT_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] reg_amt_i,
    input  logic              use_imm_i,
    input  logic [1:0]        op_i,
    output logic [DATA_W-1:0] result_o,
    output logic [FLAG_N-1:0] flag_val_o,
    output logic [FLAG_N-1:0] flag_wr_o
);
    shift_ctl_t        ctl;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] core_in;
    logic [DATA_W-1:0] core_out;
    logic              fill;
    logic              carry;
    flag_vec_t         fval;
    flag_vec_t         fwr;

    assign ctl = decode_op(op_i);

    shf_amount_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amt (
        .imm_i     (imm_i),
        .reg_amt_i (reg_amt_i),
        .use_imm_i (use_imm_i),
        .amt_o     (amt)
    );

    // Left shifts reuse the right-shift core on a bit-reversed word.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            core_in[i] = ctl.left ? opnd_i[DATA_W-1-i] : opnd_i[i];
        end
    end

    assign fill = ctl.arith & opnd_i[DATA_W-1];

    shf_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .data_i     (core_in),
        .amt_i      (amt),
        .fill_i     (fill),
        .data_o     (core_out),
        .last_out_o (carry)
    );

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            result_o[i] = ctl.left ? core_out[DATA_W-1-i] : core_out[i];
        end
    end

    shf_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .result_i (result_o),
        .carry_i  (carry),
        .val_o    (fval),
        .wr_o     (fwr)
    );

    assign flag_val_o = fval;
    assign flag_wr_o  = fwr;

    always_comb begin
        // R2: arithmetic right keeps the sign bit in place
        if (op_i == SH_SAR)
            p_sign_kept_r2: assert (result_o[DATA_W-1] == opnd_i[DATA_W-1]);
        // R3: logical right by a nonzero distance clears the top bit
        if ((op_i == SH_SHR || op_i == SH_SHR2) && amt != '0)
            p_top_zero_r3: assert (result_o[DATA_W-1] == 1'b0);
        // R4: left shift by a nonzero distance clears the bottom bit
        if (op_i == SH_SHL && amt != '0)
            p_low_zero_r4: assert (result_o[0] == 1'b0);
        // R7: zero distance passes the word and clears carry
        if (amt == '0)
            p_identity_r7: assert (result_o == opnd_i && flag_val_o[2] == 1'b0);
        // R8: zero flag agrees with the result seen at the port
        p_zero_flag_r8: assert (flag_val_o[0] == (result_o == '0));
    end
endmodule

// File: tb/shf_unit_test.sv
module shf_unit_test;
    localparam int NV = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd_i = '0;
    logic [4:0]  imm_i = '0;
    logic [31:0] reg_amt_i = '0;
    logic        use_imm_i = 1'b0;
    logic [1:0]  op_i = '0;
    logic [31:0] result_o;
    logic [4:0]  flag_val_o;
    logic [4:0]  flag_wr_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    shf_unit uut (
        .opnd_i     (opnd_i),
        .imm_i      (imm_i),
        .reg_amt_i  (reg_amt_i),
        .use_imm_i  (use_imm_i),
        .op_i       (op_i),
        .result_o   (result_o),
        .flag_val_o (flag_val_o),
        .flag_wr_o  (flag_wr_o)
    );

    // op, use_imm, imm, reg, operand, expected result, expected carry
    localparam logic [1:0]  T_OP  [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd2, 2'd0, 2'd3, 2'd1, 2'd2};
    localparam logic        T_UI  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [4:0]  T_IMM [NV] = '{5'd4, 5'd1, 5'd0, 5'd31, 5'd1, 5'd0, 5'd0, 5'd31, 5'd4, 5'd7, 5'd31};
    localparam logic [31:0] T_REG [NV] = '{32'h0, 32'h0, 32'h0000_0024, 32'h0, 32'h0, 32'h0000_0008,
                                           32'h0, 32'h0, 32'h0, 32'hFFFF_FFE0, 32'h0};
    localparam logic [31:0] T_OPN [NV] = '{32'h8000_00F0, 32'h0000_0003, 32'hF000_0008, 32'h8000_0000,
                                           32'h8000_0001, 32'h1234_5678, 32'hDEAD_BEEF, 32'h4000_0000,
                                           32'hF000_0000, 32'h8000_0000, 32'h0000_0003};
    localparam logic [31:0] T_RES [NV] = '{32'hF800_000F, 32'h0000_0001, 32'h0F00_0000, 32'h0000_0001,
                                           32'h0000_0002, 32'h3456_7800, 32'hDEAD_BEEF, 32'h0000_0000,
                                           32'h0F00_0000, 32'h8000_0000, 32'h8000_0000};
    localparam logic        T_CY  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [4:0] exp_flags(input logic [31:0] res, input logic cy);
        return {1'b0, 1'b0, cy, res[31], (res == 32'h0)};
    endfunction

    task automatic apply(input logic [1:0] op, input logic ui, input logic [4:0] im,
                         input logic [31:0] ra, input logic [31:0] d);
        @(negedge clk);
        op_i = op; use_imm_i = ui; imm_i = im; reg_amt_i = ra; opnd_i = d;
        #2;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] mres;
        logic        mcy;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        // Reset state: zero inputs give zero result with zero flag set (R8, R9)
        check("R8 reset result", result_o, 32'h0);
        check("R8 reset flags", {27'h0, flag_val_o}, 32'h0000_0001);
        check("R9 reset mask", {27'h0, flag_wr_o}, 32'h0000_000F);

        for (int v = 0; v < NV; v++) begin
            apply(T_OP[v], T_UI[v], T_IMM[v], T_REG[v], T_OPN[v]);
            // R1..R8, R10 vectors: result, carry and flags
            check($sformatf("R5 R6 vec%0d result", v), result_o, T_RES[v]);
            check($sformatf("R8 vec%0d flags", v), {27'h0, flag_val_o}, {27'h0, exp_flags(T_RES[v], T_CY[v])});
            check($sformatf("R9 vec%0d mask", v), {27'h0, flag_wr_o}, 32'h0000_000F);
        end

        // Sweep all distances for every code against operator-based model
        for (int op = 0; op < 4; op++) begin
            for (int n = 0; n < 32; n++) begin
                logic [31:0] d;
                d = 32'hA5C3_0F96 ^ (32'h0101_0101 * n);
                apply(op[1:0], 1'b1, n[4:0], 32'hFFFF_FFFF, d);
                case (op)
                    0:       mres = $unsigned($signed(d) >>> n);
                    2:       mres = d << n;
                    default: mres = d >> n;
                endcase
                if (n == 0)       mcy = 1'b0;
                else if (op == 2) mcy = d[32 - n];
                else              mcy = d[n - 1];
                check($sformatf("R2 R3 R4 sweep op%0d n%0d", op, n), result_o, mres);
                check($sformatf("R5 R6 R7 sweep op%0d n%0d", op, n), {27'h0, flag_val_o}, {27'h0, exp_flags(mres, mcy)});
            end
        end

        // R1: immediate ignored when register source selected
        apply(2'd1, 1'b0, 5'd7, 32'h0000_0002, 32'h0000_0100);
        check("R1 imm ignored", result_o, 32'h0000_0040);
        // R1: register ignored when immediate selected
        apply(2'd1, 1'b1, 5'd2, 32'h0000_0007, 32'h0000_0100);
        check("R1 reg ignored", result_o, 32'h0000_0040);
        // R10: code 3 on a negative word does not sign-fill
        apply(2'd3, 1'b1, 5'd1, 32'h0, 32'h8000_0002);
        check("R10 code3 result", result_o, 32'h4000_0001);
        check("R10 code3 flags", {27'h0, flag_val_o}, 32'h0000_0000);
        // R2: all-ones stays all-ones with carry
        apply(2'd0, 1'b1, 5'd31, 32'h0, 32'hFFFF_FFFF);
        check("R2 all ones", result_o, 32'hFFFF_FFFF);
        check("R2 R5 all ones flags", {27'h0, flag_val_o}, 32'h0000_0006);
        // R11: output follows an input change in the same cycle
        @(negedge clk);
        opnd_i = 32'h0000_0010; op_i = 2'd2; use_imm_i = 1'b1; imm_i = 5'd4;
        #1;
        check("R11 same cycle", result_o, 32'h0000_0100);
        opnd_i = 32'h0000_0020;
        #1;
        check("R11 follows change", result_o, 32'h0000_0200);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule